// File: doc/BRIEF.md
# Sequential Carry-Save Shift Multiplier

This block multiplies two unsigned `N`-bit operands using one row of `N` full adders and a few `N`-bit registers. It does not use an `N`×`N` adder array. The running sum stays in redundant form: a sum vector plus a vector of saved carries. Carries never ripple across columns within one cycle, so the clock period is about one full-adder delay and does not depend on `N`.

A run has two phases of `N` cycles each.

- **Accumulate phase.** Each cycle, the lowest bit of the multiplier register gates the multiplicand into a partial product. The adder row adds that partial product to the sum and carry vectors. The result is shifted right by one, and the bit that drops out enters the top of the multiplier register as a finished low-order product bit.
- **Flush phase.** The partial product is forced to zero and nothing shifts. Each saved carry moves up one column per cycle until none remain.

After both phases, the sum register holds the upper half of the product and the multiplier register holds the lower half. The block then pulses `done_o` for one cycle.

A client pulses `start_i` with both operands while `busy_o` is low. It then waits `2N` busy cycles for the `done_o` pulse. The result stays on `product_o` until the next accepted start.

Top module: `csa_shift_mult`

## Requirements
- R1: While reset is applied and directly after it, `busy_o` and `done_o` are 0 and `product_o` is all zeros.
- R2: A `start_i` sampled high on a clock edge while `busy_o` is low raises `busy_o` after that edge. `busy_o` then stays high for exactly 2N cycles, and `done_o` is high in the cycle right after them.
- R3: When `done_o` is high, `product_o` equals the unsigned product of the accepted operands. Bits [2N-1:N] are the upper half and bits [N-1:0] are the lower half.
- R4: `done_o` is high for exactly one cycle per accepted start.
- R5: A `start_i` pulse while `busy_o` is high has no effect: the result and the timing of the run in progress do not change, and no extra `done_o` pulse follows.
- R6: A `start_i` given in the same cycle that `done_o` is high is accepted, so runs can follow each other with no idle cycle.
- R7: After `done_o`, `product_o` keeps its value until the next accepted start.
- R8: During the accumulate phase the topmost saved-carry slot is always empty. During the flush phase no carry leaves the top column. When `done_o` is high, all saved carries are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, sampled only when idle |
| mcand_i | input | N | Multiplicand, captured on an accepted start |
| mplier_i | input | N | Multiplier, captured on an accepted start |
| busy_o | output | 1 | High while a multiplication is running |
| done_o | output | 1 | One-cycle pulse when the product is valid |
| product_o | output | 2N | Upper half from the sum register, lower half from the multiplier register |

## Verification
The hardest case to reach from the ports is a long chain of saved carries that must still be in flight when the flush phase begins. If such a chain does not fully drain, only the upper product bits go wrong. Operands with every bit set produce the longest carry chains, so the stimulus includes all-ones times all-ones and all-ones times one, alongside zero operands and random pairs. Runs are issued back to back on the `done_o` cycle. Starts that arrive mid-run are also injected, to show they leave both the result and the completion cycle unchanged.

// File: rtl/csm_pkg.sv
package csm_pkg;

    // Which half of a run the datapath is in
    typedef enum logic {
        PH_ACCUM = 1'b0,   // partial products enter, sum shifts right
        PH_FLUSH = 1'b1    // no partial product, carries move up in place
    } csm_phase_e;

endpackage

// File: rtl/csm_full_adder.sv
module csm_full_adder (
    input  logic x_i,
    input  logic y_i,
    input  logic z_i,
    output logic s_o,
    output logic c_o
);

    assign s_o = x_i ^ y_i ^ z_i;
    assign c_o = (x_i & y_i) | (x_i & z_i) | (y_i & z_i);

endmodule

// File: rtl/csm_csa_row.sv
module csm_csa_row #(
    parameter int unsigned N = 32
) (
    input  logic [N-1:0] x_i,
    input  logic [N-1:0] y_i,
    input  logic [N-1:0] z_i,
    output logic [N-1:0] s_o,
    output logic [N-1:0] c_o   // c_o[k] carries weight of column k+1
);

    // One independent full adder per column; no carry links between them
    for (genvar k = 0; k < N; k++) begin : g_col
        csm_full_adder i_fa (
            .x_i (x_i[k]),
            .y_i (y_i[k]),
            .z_i (z_i[k]),
            .s_o (s_o[k]),
            .c_o (c_o[k])
        );
    end

endmodule

// File: rtl/csa_shift_mult.sv
module csa_shift_mult #(
    parameter int unsigned N = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_i,
    input  logic [N-1:0]   mcand_i,
    input  logic [N-1:0]   mplier_i,
    output logic           busy_o,
    output logic           done_o,
    output logic [2*N-1:0] product_o
);

    import csm_pkg::*;

    localparam int unsigned CW       = (N > 2) ? $clog2(N) : 1;
    localparam logic [CW-1:0] LAST_STEP = CW'(N - 1);

    typedef struct packed {
        logic          busy;
        logic          done;
        csm_phase_e    phase;
        logic [CW-1:0] step;
        logic [N-1:0]  mcand;
        logic [N-1:0]  sum;    // sum vector of the carry-save accumulator
        logic [N-1:0]  cry;    // cry[k] is a pending carry into column k
        logic [N-1:0]  mreg;   // multiplier bits below, finished bits above
    } csm_state_t;

    csm_state_t st_d, st_q;

    logic [N-1:0] pp;
    logic [N-1:0] row_s;
    logic [N-1:0] row_c;

    // Partial product: gated multiplicand while accumulating, zero while flushing
    always_comb begin
        if (st_q.busy && st_q.phase == PH_ACCUM && st_q.mreg[0]) begin
            pp = st_q.mcand;
        end else begin
            pp = '0;
        end
    end

    csm_csa_row #(.N(N)) i_row (
        .x_i (st_q.sum),
        .y_i (st_q.cry),
        .z_i (pp),
        .s_o (row_s),
        .c_o (row_c)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!st_q.busy) begin
            if (start_i) begin
                st_d.busy  = 1'b1;
                st_d.phase = PH_ACCUM;
                st_d.step  = '0;
                st_d.mcand = mcand_i;
                st_d.mreg  = mplier_i;
                st_d.sum   = '0;
                st_d.cry   = '0;
            end
        end else if (st_q.phase == PH_ACCUM) begin
            // Retire column 0 into the multiplier register and shift right.
            // The top column's carry becomes the new top sum bit.
            st_d.mreg = {row_s[0], st_q.mreg[N-1:1]};
            st_d.sum  = {row_c[N-1], row_s[N-1:1]};
            st_d.cry  = {1'b0, row_c[N-2:0]};
            if (st_q.step == LAST_STEP) begin
                st_d.phase = PH_FLUSH;
                st_d.step  = '0;
            end else begin
                st_d.step = st_q.step + 1'b1;
            end
        end else begin
            // No shift: each carry advances one column to the left
            st_d.sum = row_s;
            st_d.cry = {row_c[N-2:0], 1'b0};
            if (st_q.step == LAST_STEP) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end else begin
                st_d.step = st_q.step + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o    = st_q.busy;
    assign done_o    = st_q.done;
    assign product_o = {st_q.sum, st_q.mreg};

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);                                                  // R4
    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);                                            // R2
    AST_DONE_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(busy_o));                                            // R4
    AST_START_BUSY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && st_q.phase == PH_ACCUM && start_i) |=> $stable(st_q.mcand)); // R5
    AST_TOP_SLOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && st_q.phase == PH_ACCUM) |-> !st_q.cry[N-1]);               // R8
    AST_NO_TOP_CARRY_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && st_q.phase == PH_FLUSH) |-> !row_c[N-1]);                  // R8
    AST_CARRIES_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (st_q.cry == '0));                                         // R8
    AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> $stable(product_o));                        // R7

endmodule

// File: tb/test_csa_shift_mult.sv
`timescale 1ns/1ps
module test_csa_shift_mult;

    localparam int unsigned N = 32;

    typedef struct packed {
        logic [2*N-1:0] prod;
        logic [31:0]    due;
    } exp_t;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           start_i = 1'b0;
    logic [N-1:0]   mcand_i = '0;
    logic [N-1:0]   mplier_i = '0;
    logic           busy_o;
    logic           done_o;
    logic [2*N-1:0] product_o;

    int unsigned n_checks = 0;
    int unsigned n_fail = 0;
    logic [31:0] cyc = 0;
    int unsigned busy_run = 0;
    exp_t exp_q[$];

    always #4 clk = ~clk;   // 125 MHz

    always @(posedge clk) cyc <= cyc + 1;

    csa_shift_mult #(.N(N)) i_csa_shift_mult (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .mcand_i   (mcand_i),
        .mplier_i  (mplier_i),
        .busy_o    (busy_o),
        .done_o    (done_o),
        .product_o (product_o)
    );

    task automatic check(input bit ok, input string req,
                         input logic [2*N-1:0] act, input logic [2*N-1:0] expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    // Driver: waits for idle, pulses start, pushes the expected item
    task automatic issue(input logic [N-1:0] a, input logic [N-1:0] b, input bit noise);
        exp_t e;
        @(negedge clk);
        while (busy_o) @(negedge clk);
        mcand_i  = a;
        mplier_i = b;
        start_i  = 1'b1;
        e.prod   = {{N{1'b0}}, a} * {{N{1'b0}}, b};
        e.due    = cyc + 2*N + 1;
        exp_q.push_back(e);
        @(negedge clk);
        start_i = 1'b0;
        if (noise) begin
            // R5: mid-run start with other operands must be ignored
            repeat (5) @(negedge clk);
            mcand_i  = ~a;
            mplier_i = b ^ 32'h5A5A_0F0F;
            start_i  = 1'b1;
            @(negedge clk);
            start_i  = 1'b0;
            repeat (N) @(negedge clk);
            mcand_i  = 32'h1234_5678;
            start_i  = 1'b1;
            @(negedge clk);
            start_i  = 1'b0;
        end
    endtask

    // Monitor: compares each done pulse against the scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (done_o) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R4 unexpected done", {{(2*N-1){1'b0}}, done_o}, '0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    check(product_o === e.prod, "R3 product", product_o, e.prod);
                    check(cyc == e.due, "R2/R6 done cycle",
                          {{N{1'b0}}, cyc}, {{N{1'b0}}, e.due});
                    check(busy_run == 2*N, "R2 busy length",
                          2*N'(busy_run), 2*N'(2*N));
                end
                busy_run = 0;
            end
            if (busy_o) busy_run++;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        check(1'b0, "watchdog", '0, '0);
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [2*N-1:0] held;
        repeat (3) @(negedge clk);
        // R1: state while reset is held
        check(!busy_o && !done_o && product_o == '0, "R1 reset state",
              {busy_o, done_o, product_o[2*N-3:0]}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy_o && !done_o && product_o == '0, "R1 after reset",
              {busy_o, done_o, product_o[2*N-3:0]}, '0);

        // Corner operands (R3)
        issue('0, 32'hDEAD_BEEF, 1'b0);
        issue(32'hCAFE_F00D, '0, 1'b0);
        issue(32'd1, 32'h8765_4321, 1'b0);
        issue(32'h8765_4321, 32'd1, 1'b0);
        issue('1, '1, 1'b0);              // longest carry chains, R8 flush
        issue('1, 32'd1, 1'b0);
        issue(32'd1, '1, 1'b0);
        issue(32'h8000_0000, 32'h8000_0000, 1'b0);
        // R5: starts injected during a run
        issue(32'h0F0F_F0F0, 32'hFFFF_0001, 1'b1);
        // Random pairs issued back to back (R6)
        for (int k = 0; k < 20; k++) begin
            issue($urandom, $urandom, 1'b0);
        end

        // R7: result held after done with no further start
        @(negedge clk);
        while (!done_o) @(negedge clk);
        held = product_o;
        repeat (6) @(negedge clk);
        check(product_o === held, "R7 result held", product_o, held);
        check(!done_o && !busy_o, "R4 done single pulse",
              {{(2*N-2){1'b0}}, done_o, busy_o}, '0);
        check(exp_q.size() == 0, "R5 no extra result",
              2*N'(exp_q.size()), '0);

        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule